// File: doc/BRIEF.md
# Multiply-Divide Accumulator Unit

This unit performs unsigned 16-bit multiplication and division one bit per clock. It places each result in a pair of accumulator registers, called high and low. The datapath issues an operation over a valid/ready request channel. The request carries an operation select, a first operand, and a second operand. The second operand comes either from a general register or from an immediate field. While an operation runs, the unit holds `busy` high and refuses new requests. It pulses `done` for one cycle when the accumulators hold the final result.

Software reads results with two separate move operations, one for the high accumulator and one for the low accumulator. Each read has its own valid/ready port. Back-pressure rules:
- A read port asserts ready only while the unit is idle, so a move issued during an operation stalls until the result is in place.
- The request channel applies the same rule: `req_ready` is low for as long as `busy` is high.
- A request held during that window is neither lost nor taken early. It is accepted in the first idle cycle.

Multiplication and division use the same shift registers as working storage. The accumulators are those registers. The divider is a restoring divider. With a zero divisor it naturally leaves an all-ones quotient and the dividend as remainder.

Top module: `muldiv_acc`

## Requirements
- R1: After reset, both accumulators read 0, `busy` and `done` are 0, and `req_ready` is 1.
- R2: With `req_op`=0 (multiply), the unsigned 2W-bit product of the operands ends with its upper W bits in the high accumulator and its lower W bits in the low accumulator.
- R3: With `req_op`=1 (divide), the unsigned quotient of first operand by second operand ends in the low accumulator and the remainder in the high accumulator.
- R4: A divide by zero completes with the same latency as any other operation. It leaves all ones in the low accumulator and the dividend in the high accumulator.
- R5: A request is accepted when `req_valid` and `req_ready` are both 1. `busy` is then high for exactly W cycles. `done` is high for exactly the one cycle after the last busy cycle. `req_ready` equals not `busy`, so a request presented while busy has no effect on the running operation.
- R6: When `req_use_imm` is 1, the second operand is `req_b_imm`; otherwise it is `req_b_reg`.
- R7: Each read port's ready is 0 while busy and 1 when idle. Its data is the matching accumulator when valid and ready are both 1, and 0 otherwise.
- R8: While idle with no accepted request, both accumulators keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 1 | 0 multiply, 1 divide |
| req_a | input | W | First operand (multiplicand / dividend) |
| req_b_reg | input | W | Second operand from a general register |
| req_b_imm | input | W | Second operand from an immediate |
| req_use_imm | input | 1 | Select immediate as second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi_rd_valid | input | 1 | Move-from-high request |
| hi_rd_ready | output | 1 | Move-from-high can complete |
| hi_rd_data | output | W | High accumulator value on handshake |
| lo_rd_valid | input | 1 | Move-from-low request |
| lo_rd_ready | output | 1 | Move-from-low can complete |
| lo_rd_data | output | W | Low accumulator value on handshake |

## Verification
An error in a single shift or subtract step corrupts one product or quotient bit. That wrong bit is visible on the read ports in the cycle after `done`. This is why every operand pair of a narrow configuration is swept, for both operations and both operand sources. A wrong step count shows up as `done` arriving one cycle early or late, and that is measured on every operation. A lost busy state would let a second request through or open the read ports mid-operation. This is checked in the first cycle after each acceptance.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    MD_MUL = 1'b0,
    MD_DIV = 1'b1
  } md_op_e;
endpackage

// File: rtl/muldiv_seq_ctrl.sv
module muldiv_seq_ctrl #(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= STEPS;
      end else if (busy) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  md_op_e       op,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] hi_nx,
  output logic [W-1:0] lo_nx
);
  logic [W:0] mul_sum;
  logic [W:0] div_sh;
  logic [W:0] div_d;
  logic       div_ge;

  always_comb begin
    // multiply: conditional add into the upper half, then shift the pair right
    mul_sum = {1'b0, hi} + (lo[0] ? {1'b0, opnd} : '0);
    // divide: shift the partial remainder left, trial-subtract the divisor
    div_sh  = {hi, lo[W-1]};
    div_d   = {1'b0, opnd};
    div_ge  = (div_sh >= div_d);
    if (op == MD_MUL) begin
      hi_nx = mul_sum[W:1];
      lo_nx = {mul_sum[0], lo[W-1:1]};
    end else begin
      hi_nx = div_ge ? W'(div_sh - div_d) : div_sh[W-1:0];
      lo_nx = {lo[W-2:0], div_ge};
    end
  end
endmodule

// File: rtl/md_read_port.sv
module md_read_port #(
  parameter int W = 16
) (
  input  logic         rd_valid,
  input  logic         busy,
  input  logic [W-1:0] acc,
  output logic         rd_ready,
  output logic [W-1:0] rd_data
);
  always_comb begin
    rd_ready = !busy;
    rd_data  = (rd_valid && rd_ready) ? acc : '0;
  end
endmodule

// File: rtl/muldiv_acc.sv
module muldiv_acc
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic         req_op,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b_reg,
  input  logic [W-1:0] req_b_imm,
  input  logic         req_use_imm,
  output logic         busy,
  output logic         done,
  input  logic         hi_rd_valid,
  output logic         hi_rd_ready,
  output logic [W-1:0] hi_rd_data,
  input  logic         lo_rd_valid,
  output logic         lo_rd_ready,
  output logic [W-1:0] lo_rd_data
);
  logic         start;
  md_op_e       op_q;
  logic [W-1:0] hi_q, lo_q, opnd_q;
  logic [W-1:0] hi_nx, lo_nx;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  muldiv_seq_ctrl #(.W(W)) ctrl_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  muldiv_step #(.W(W)) step_i (
    .op    (op_q),
    .hi    (hi_q),
    .lo    (lo_q),
    .opnd  (opnd_q),
    .hi_nx (hi_nx),
    .lo_nx (lo_nx)
  );

  // the working shift registers double as the accumulator pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      opnd_q <= '0;
      op_q   <= MD_MUL;
    end else if (start) begin
      hi_q   <= '0;
      lo_q   <= req_a;
      opnd_q <= req_use_imm ? req_b_imm : req_b_reg;
      op_q   <= md_op_e'(req_op);
    end else if (busy) begin
      hi_q <= hi_nx;
      lo_q <= lo_nx;
    end
  end

  md_read_port #(.W(W)) hi_port_i (
    .rd_valid (hi_rd_valid),
    .busy     (busy),
    .acc      (hi_q),
    .rd_ready (hi_rd_ready),
    .rd_data  (hi_rd_data)
  );

  md_read_port #(.W(W)) lo_port_i (
    .rd_valid (lo_rd_valid),
    .busy     (busy),
    .acc      (lo_q),
    .rd_ready (lo_rd_ready),
    .rd_data  (lo_rd_data)
  );
endmodule

// File: rtl/muldiv_acc_chk.sv
module muldiv_acc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         busy,
  input logic         done,
  input logic         hi_rd_ready,
  input logic         lo_rd_ready,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r5_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_idle_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> req_ready);

  a_r7_no_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!hi_rd_ready && !lo_rd_ready));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_valid && req_ready)) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

bind muldiv_acc muldiv_acc_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .busy        (busy),
  .done        (done),
  .hi_rd_ready (hi_rd_ready),
  .lo_rd_ready (lo_rd_ready),
  .hi_q        (hi_q),
  .lo_q        (lo_q)
);

// File: tb/muldiv_acc_tb_top.sv
module muldiv_acc_tb_top;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_op = 1'b0;
  logic [W-1:0] req_a = '0, req_b_reg = '0, req_b_imm = '0;
  logic         req_use_imm = 1'b0;
  logic         busy, done;
  logic         hi_rd_valid = 1'b1, lo_rd_valid = 1'b1;
  logic         hi_rd_ready, lo_rd_ready;
  logic [W-1:0] hi_rd_data, lo_rd_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  muldiv_acc #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_a(req_a), .req_b_reg(req_b_reg), .req_b_imm(req_b_imm),
    .req_use_imm(req_use_imm), .busy(busy), .done(done),
    .hi_rd_valid(hi_rd_valid), .hi_rd_ready(hi_rd_ready), .hi_rd_data(hi_rd_data),
    .lo_rd_valid(lo_rd_valid), .lo_rd_ready(lo_rd_ready), .lo_rd_data(lo_rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one operation; returns with the bench at the negedge where done is seen
  task automatic run_op(input bit op, input int a, input int b, input bit use_imm,
                        input bit poke_busy);
    int n;
    @(negedge clk);
    check("R5 ready before issue", int'(req_ready), 1);
    req_valid   = 1'b1;
    req_op      = op;
    req_a       = W'(a);
    req_use_imm = use_imm;
    req_b_imm   = use_imm ? W'(b) : W'(~b);
    req_b_reg   = use_imm ? W'(~b) : W'(b);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    check("R5 busy after accept", int'(busy), 1);
    check("R7 hi ready low while busy", int'(hi_rd_ready), 0);
    check("R7 lo data zero while busy", int'(lo_rd_data), 0);
    if (poke_busy) begin
      // R5: a request while busy must not disturb the running operation
      req_valid = 1'b1; req_op = ~op; req_a = W'(~a);
      req_b_reg = W'(a); req_b_imm = W'(a);
      check("R5 ready low while busy", int'(req_ready), 0);
      @(negedge clk); n++;
      req_valid = 1'b0;
    end
    while (!done && n < 4 * W) begin
      @(negedge clk); n++;
    end
    check("R5 done latency", n, W + 1);
    check("R5 busy low at done", int'(busy), 0);
    check("R7 hi ready at done", int'(hi_rd_ready), 1);
  endtask

  task automatic expect_result(input bit op, input int a, input int b);
    int eh, el;
    if (op == 1'b0) begin
      eh = ((a * b) >> W) & (M - 1);
      el = (a * b) & (M - 1);
      check("R2 mult high", int'(hi_rd_data), eh);
      check("R2 mult low", int'(lo_rd_data), el);
    end else if (b == 0) begin
      check("R4 div0 high=dividend", int'(hi_rd_data), a);
      check("R4 div0 low=ones", int'(lo_rd_data), M - 1);
    end else begin
      check("R3 div remainder", int'(hi_rd_data), a % b);
      check("R3 div quotient", int'(lo_rd_data), a / b);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 hi after reset", int'(hi_rd_data), 0);
    check("R1 lo after reset", int'(lo_rd_data), 0);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
    check("R1 ready after reset", int'(req_ready), 1);

    // exhaustive sweep, both ops, operand source alternating (R6)
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++) begin
          run_op(op[0], a, b, ((a + b) % 2) == 1, 1'b0);
          expect_result(op[0], a, b);
        end

    // R6 explicit both sources for one pair
    run_op(1'b0, 13, 11, 1'b1, 1'b0);
    check("R6 imm selected", int'(lo_rd_data), (13 * 11) & (M - 1));
    run_op(1'b0, 13, 11, 1'b0, 1'b0);
    check("R6 reg selected", int'(lo_rd_data), (13 * 11) & (M - 1));

    // R5 request while busy ignored
    run_op(1'b1, 14, 3, 1'b0, 1'b1);
    expect_result(1'b1, 14, 3);
    @(negedge clk);
    check("R5 no second start", int'(busy), 0);

    // R8 hold and R7 gating by valid
    repeat (5) @(negedge clk);
    check("R8 hi held", int'(hi_rd_data), 14 % 3);
    check("R8 lo held", int'(lo_rd_data), 14 / 3);
    hi_rd_valid = 1'b0; lo_rd_valid = 1'b0;
    #0;
    @(negedge clk);
    check("R7 hi data zero without valid", int'(hi_rd_data), 0);
    check("R7 lo data zero without valid", int'(lo_rd_data), 0);
    hi_rd_valid = 1'b1; lo_rd_valid = 1'b1;
    @(negedge clk);
    check("R8 lo still held", int'(lo_rd_data), 14 / 3);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule